// File: doc/BRIEF.md
# Double to single store converter

This block turns a 64-bit IEEE double-precision register value into the 32-bit single-precision word that a store-single operation writes to memory. It never rounds. Fraction bits that do not fit are dropped. Values with a large enough exponent, zeros, infinities, NaNs and values beyond the single range all go through a fixed bit selection. Values whose magnitude falls in the single denormal range are denormalized with a variable right shift. Anything smaller becomes a zero that keeps the sign.

The conversion is split into three pieces:

- A classifier. It sorts the input into one of three classes: `CLS_DIRECT`, `CLS_DENORM` and `CLS_TINY`. For the denormal class it also computes the shift amount.
- A logarithmic right shifter, built with generate.
- A packer, which assembles the output word.

The parameter `REGISTERED` selects between two variants:

- **Combinational (`REGISTERED = 0`):** the word and the valid follow the input in the same cycle.
- **Registered (`REGISTERED = 1`):** a two-state output machine holds the result.
  - The states are `ST_IDLE` (no fresh result) and `ST_SHOW` (a result was captured on the last edge).
  - `ST_IDLE` goes to `ST_SHOW` when `in_valid` is high.
  - `ST_SHOW` stays in `ST_SHOW` when `in_valid` is high again.
  - `ST_SHOW` returns to `ST_IDLE` when `in_valid` is low.
  - The word register loads only on a valid input and otherwise holds its value.

Top module: `d2s_store_conv`

## Requirements
- R1: No rounding is applied. Input fraction bits below those copied are discarded whatever their value; for example 0x3FF000001FFFFFFF converts to 0x3F800000.
- R2: Output bit 31 always equals input bit 63.
- R3: With biased exponent X = in[62:52], when X >= 897 or in[62:0] is zero, the output is {in[63], in[62], in[58:52], in[51:29]}; for example 1.0 (0x3FF0000000000000) gives 0x3F800000.
- R4: Values above the largest single (X > 1150), including infinity and NaN, use the R3 bit copy with no saturation to infinity.
- R5: When 874 <= X <= 896, the output exponent field [30:23] is zero and [22:0] equals {1, in[51:0]} shifted right by 926 - X. This covers shifts 30 (X = 896, result 0x00400000) to 52 (X = 874, result 0x00000001).
- R6: When X <= 873 and in[62:0] is nonzero, the output is {in[63], 31 zero bits}.
- R7: A double denormal input (X = 0, nonzero fraction) yields a signed zero.
- R8: With REGISTERED = 1, out_valid is high in the cycle after each cycle with in_valid high, and out_word then carries that input's result.
- R9: With REGISTERED = 1, a cycle with in_valid low makes out_valid low in the next cycle and leaves out_word unchanged whatever in_dbl holds.
- R10: With REGISTERED = 0, out_valid equals in_valid and out_word is the conversion of in_dbl in the same cycle.
- R11: After reset with REGISTERED = 1, out_valid is 0 and out_word is 0 until the first valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input value present |
| in_dbl | input | 64 | Double-precision register value |
| out_valid | output | 1 | Output word present |
| out_word | output | 32 | Single-precision store word |

## Verification
The bench builds two copies side by side: the default `REGISTERED = 1` and a `REGISTERED = 0` copy fed the same stimulus. Each vector is checked at both outputs. The combinational copy exposes the conversion in the drive cycle (R10). The registered copy exposes the one-cycle latency, the hold of the word and the reset value. Directed inputs sit on the class boundaries X = 873, 874, 896 and 897, and on zero, infinity, NaN, huge values and double denormals. Random inputs are biased so that about half land in or near the denormal window.

// File: rtl/d2s_pkg.sv
package d2s_pkg;
    localparam int DBL_W      = 64;
    localparam int SGL_W      = 32;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int DBL_BIAS   = 1023;
    localparam int SGL_BIAS   = 127;
    // lowest biased double exponent copied directly
    localparam int DIRECT_EXP_MIN = DBL_BIAS - SGL_BIAS + 1;
    // lowest biased double exponent still giving a nonzero single denormal
    localparam int DENORM_EXP_MIN = DBL_BIAS - SGL_BIAS - SGL_FRAC_W + 1;
    // low single exponent bits copied straight from the double exponent
    localparam int LOW_EXP_W = SGL_EXP_W - 1;
    // fraction bits dropped on the direct path
    localparam int DROP_W = DBL_FRAC_W - SGL_FRAC_W;
    // shifter: extra right shift beyond the minimum denormal shift
    localparam int RSH_W = $clog2(SGL_FRAC_W);

    typedef enum logic [1:0] {
        CLS_DIRECT = 2'd0,
        CLS_DENORM = 2'd1,
        CLS_TINY   = 2'd2
    } conv_cls_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } out_st_e;
endpackage

// File: rtl/d2s_classify.sv
module d2s_classify
    import d2s_pkg::*;
(
    input  logic [DBL_W-2:0] mag,
    output conv_cls_e        cls,
    output logic [RSH_W-1:0] rsh
);
    logic [DBL_EXP_W-1:0] bexp;
    logic                 mag_zero;

    assign bexp     = mag[DBL_W-2:DBL_FRAC_W];
    assign mag_zero = (mag == '0);

    always_comb begin
        cls = CLS_TINY;
        rsh = '0;
        if (mag_zero || (bexp >= DBL_EXP_W'(DIRECT_EXP_MIN))) begin
            cls = CLS_DIRECT;
        end else if (bexp >= DBL_EXP_W'(DENORM_EXP_MIN)) begin
            cls = CLS_DENORM;
            rsh = RSH_W'(DIRECT_EXP_MIN - 1 - int'(bexp));
        end
    end

    // R5
    always_comb begin
        if (cls == CLS_DENORM) begin
            shift_range_chk: assert (rsh <= RSH_W'(SGL_FRAC_W - 1))
                else $error("denormal shift out of range");
        end
    end
endmodule

// File: rtl/d2s_denorm.sv
module d2s_denorm
    import d2s_pkg::*;
(
    input  logic [SGL_FRAC_W-1:0] sig_top,
    input  logic [RSH_W-1:0]      rsh,
    output logic [SGL_FRAC_W-1:0] frac
);
    logic [SGL_FRAC_W-1:0] stg [0:RSH_W];

    assign stg[0] = sig_top;

    generate
        for (genvar i = 0; i < RSH_W; i++) begin : g_stage
            assign stg[i+1] = rsh[i] ? (stg[i] >> (1 << i)) : stg[i];
        end
    endgenerate

    assign frac = stg[RSH_W];
endmodule

// File: rtl/d2s_pack.sv
module d2s_pack
    import d2s_pkg::*;
(
    input  conv_cls_e             cls,
    input  logic                  sign,
    input  logic                  exp_msb,
    input  logic [LOW_EXP_W-1:0]  exp_low,
    input  logic [SGL_FRAC_W-1:0] frac_hi,
    input  logic [SGL_FRAC_W-1:0] den_frac,
    output logic [SGL_W-1:0]      word
);
    always_comb begin
        unique case (cls)
            CLS_DIRECT: word = {sign, exp_msb, exp_low, frac_hi};
            CLS_DENORM: word = {sign, {SGL_EXP_W{1'b0}}, den_frac};
            CLS_TINY:   word = {sign, {(SGL_W-1){1'b0}}};
            default:    word = {sign, {(SGL_W-1){1'b0}}};
        endcase
    end
endmodule

// File: rtl/d2s_store_conv.sv
module d2s_store_conv
    import d2s_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] in_dbl,
    output logic             out_valid,
    output logic [SGL_W-1:0] out_word
);
    conv_cls_e             cls;
    logic [RSH_W-1:0]      rsh;
    logic [SGL_FRAC_W-1:0] den_frac;
    logic [SGL_W-1:0]      conv_word;
    logic                  tiny_in;

    d2s_classify u_classify (
        .mag (in_dbl[DBL_W-2:0]),
        .cls (cls),
        .rsh (rsh)
    );

    d2s_denorm u_denorm (
        .sig_top ({1'b1, in_dbl[DBL_FRAC_W-1:DROP_W+1]}),
        .rsh     (rsh),
        .frac    (den_frac)
    );

    d2s_pack u_pack (
        .cls      (cls),
        .sign     (in_dbl[DBL_W-1]),
        .exp_msb  (in_dbl[DBL_W-2]),
        .exp_low  (in_dbl[DBL_FRAC_W+LOW_EXP_W-1:DBL_FRAC_W]),
        .frac_hi  (in_dbl[DBL_FRAC_W-1:DROP_W]),
        .den_frac (den_frac),
        .word     (conv_word)
    );

    assign tiny_in = (in_dbl[DBL_W-2:0] != '0) &&
                     (in_dbl[DBL_W-2:DBL_FRAC_W] < DBL_EXP_W'(DENORM_EXP_MIN));

    generate
        if (REGISTERED) begin : g_reg
            out_st_e          st_q;
            out_st_e          st_d;
            logic [SGL_W-1:0] word_q;

            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    ST_IDLE: if (in_valid)  st_d = ST_SHOW;
                    ST_SHOW: if (!in_valid) st_d = ST_IDLE;
                    default: st_d = ST_IDLE;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= ST_IDLE;
                else        st_q <= st_d;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        word_q <= '0;
                else if (in_valid) word_q <= conv_word;
            end

            assign out_valid = (st_q == ST_SHOW);
            assign out_word  = word_q;

            // R8
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R9
            valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R9
            word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_word));
            // R2
            sign_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_word[SGL_W-1] == $past(in_dbl[DBL_W-1]));
            // R6
            tiny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && tiny_in) |=> out_word[SGL_W-2:0] == '0);
            // R5
            denorm_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && cls == CLS_DENORM) |=>
                    out_word[SGL_W-2:SGL_FRAC_W] == '0);
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_word  = conv_word;

            // R2
            sign_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> out_word[SGL_W-1] == in_dbl[DBL_W-1]);
            // R6
            tiny_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && tiny_in) |-> out_word[SGL_W-2:0] == '0);
        end
    endgenerate
endmodule

// File: tb/test_d2s_store_conv.sv
module test_d2s_store_conv;
    localparam time CLK_HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_dbl = '0;
    logic        r_valid, c_valid;
    logic [31:0] r_word, c_word;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    d2s_store_conv #(.REGISTERED(1'b1)) i_d2s_store_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .out_valid(r_valid), .out_word(r_word));

    d2s_store_conv #(.REGISTERED(1'b0)) i_d2s_store_conv_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .out_valid(c_valid), .out_word(c_word));

    function automatic logic [31:0] model(input logic [63:0] d);
        int          x;
        logic [52:0] sig;
        x   = int'(d[62:52]);
        sig = {1'b1, d[51:0]};
        if (x >= 897 || d[62:0] == 63'd0)
            return {d[63], d[62], d[58:52], d[51:29]};
        else if (x >= 874)
            return {d[63], 8'd0, 23'(sig >> (926 - x))};
        else
            return {d[63], 31'd0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // Drive one valid vector, check comb copy now and registered copy after the edge.
    task automatic send(input logic [63:0] d, input string req, input logic [31:0] exp_v);
        logic [31:0] m;
        m = model(d);
        in_valid = 1'b1;
        in_dbl   = d;
        #1;
        check({req, " R10 comb valid"}, {31'd0, c_valid}, 32'd1);
        check({req, " R10 comb word"}, c_word, exp_v);
        @(negedge clk);
        check({req, " R8 reg valid"}, {31'd0, r_valid}, 32'd1);
        check({req, " R8 reg word"}, r_word, exp_v);
        if (exp_v !== m) check({req, " model"}, m, exp_v);
    endtask

    // Idle cycle with junk data: registered word must hold.
    task automatic idle_check(input logic [31:0] held);
        in_valid = 1'b0;
        in_dbl   = {$urandom, $urandom};
        #1;
        check("R10 comb idle valid", {31'd0, c_valid}, 32'd0);
        @(negedge clk);
        check("R9 reg idle valid", {31'd0, r_valid}, 32'd0);
        check("R9 reg hold word", r_word, held);
    endtask

    function automatic logic [63:0] mk(input bit s, input int x, input logic [51:0] f);
        return {s, 11'(x), f};
    endfunction

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        // R11
        check("R11 reset valid", {31'd0, r_valid}, 32'd0);
        check("R11 reset word", r_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", {31'd0, r_valid}, 32'd0);

        send(64'h3FF0000000000000, "R3 one", 32'h3F800000);
        send(64'h3FF000001FFFFFFF, "R1 truncate", 32'h3F800000);
        send(64'hBFFFFFFFFFFFFFFF, "R1 truncate neg", 32'hBFFFFFFF);
        idle_check(32'hBFFFFFFF);
        send(64'h0000000000000000, "R3 zero", 32'h00000000);
        send(64'h8000000000000000, "R2 neg zero", 32'h80000000);
        send(64'h7FF0000000000000, "R4 inf", 32'h7F800000);
        send(64'hFFF8000000000001, "R4 nan", 32'hFFC00000);
        send(mk(1'b0, 1200, 52'hABCDE_12345678), "R4 huge", model(mk(1'b0, 1200, 52'hABCDE_12345678)));
        send(mk(1'b0, 897, 52'd0), "R3 min normal", 32'h00800000);
        send(mk(1'b0, 896, 52'd0), "R5 top denorm", 32'h00400000);
        send(mk(1'b1, 896, 52'hFFFFFFFFFFFFF), "R5 top denorm ones", 32'h807FFFFF);
        send(mk(1'b0, 874, 52'hFFFFFFFFFFFFF), "R5 bottom denorm", 32'h00000001);
        send(mk(1'b0, 885, 52'h8000000000000), "R5 mid denorm", 32'h00000C00);
        send(mk(1'b0, 873, 52'hFFFFFFFFFFFFF), "R6 tiny", 32'h00000000);
        send(mk(1'b1, 500, 52'h1234), "R6 tiny neg", 32'h80000000);
        send(mk(1'b1, 0, 52'h1), "R7 dbl denorm neg", 32'h80000000);
        send(mk(1'b0, 0, 52'hFFFFFFFFFFFFF), "R7 dbl denorm", 32'h00000000);
        idle_check(32'h00000000);

        for (int k = 0; k < 400; k++) begin
            logic [63:0] d;
            int          x;
            int          sel;
            sel = int'($urandom % 4);
            case (sel)
                0: x = 872 + int'($urandom % 27);
                1: x = int'($urandom % 2048);
                2: x = 860 + int'($urandom % 50);
                default: x = 897 + int'($urandom % 400);
            endcase
            d = mk(1'($urandom), x, {20'($urandom), $urandom});
            send(d, "R5 R3 random", model(d));
            if ((k % 7) == 0) idle_check(model(d));
        end

        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule